// File: doc/BRIEF.md
# CAN Message Buffer Manager

This block is the storage between a host processor and a CAN bit stream engine. It has one ten-byte transmit buffer and a pair of ten-byte receive buffers. All three use the same layout. Byte 0 carries identifier bits 10 to 3. Byte 1 carries identifier bits 2 to 0, then the remote-request bit, then the four-bit length code. Bytes 2 to 9 carry data bytes 1 to 8.

The host fills the transmit buffer and then raises a send request. From that point the buffer belongs to the core until the core reports completion, or until an abort arrives before the core has started sending.

Received frames pass through a mask-and-compare filter on identifier bits 10 to 3. Accepted frames go into whichever receive buffer is free. The host always sees the oldest complete frame through a single address window. Releasing that frame exposes the other buffer. When a third accepted frame completes while both buffers are still held, the block raises an overrun flag and a one-cycle overrun interrupt.

Top module: `can_msgbuf`

## Requirements
- R1: After reset, tx_access is 1, tx_pending and tx_active are 0, rx_ready is 0, ovr_flag is 0 and ovr_irq is 0.
- R2: A host write to offsets 0x2A..0x33 stores the byte at transmit index offset-0x2A. A host read of the same offset returns it one cycle later on host_rdata. A core read at core_tx_addr returns the same byte one cycle later on core_tx_rdata.
- R3: A pulse on cmd_tx_req while tx_access is 1 locks the buffer: tx_access goes to 0 and tx_pending goes to 1. Host writes to the transmit window are ignored while the buffer is locked, so a later read returns the old byte.
- R4: cmd_abort while tx_pending is 1 unlocks the buffer (tx_access goes to 1). After core_tx_start, tx_active is 1 and cmd_abort has no effect. core_tx_done then unlocks the buffer.
- R5: A frame that the core writes through core_rx_we/core_rx_addr/core_rx_wdata, closed by core_rx_end and accepted by the filter, sets rx_ready. The frame then reads back at offsets 0x34..0x3D.
- R6: A second frame lands in the other buffer while the first is still shown. cmd_release frees the shown buffer and exposes the second. rx_ready stays 1 while any full buffer remains.
- R7: An accepted frame that ends while both buffers are full sets ovr_flag and pulses ovr_irq for exactly one cycle. It is not stored, and both held frames stay intact.
- R8: cmd_clr_ovr clears ovr_flag.
- R9: A frame is accepted when ((id_msbs XOR acc_code) AND NOT acc_mask) is zero, where a mask bit of 1 means don't care. A rejected frame neither sets rx_ready nor changes the window.
- R10: A frame that ends with core_rx_err is discarded. The buffer it was filling stays empty, and the next good frame is shown normally.
- R11: cmd_release while no buffer is full has no effect on rx_ready or on which buffer the next frame is shown from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 6 | Host byte offset |
| host_we | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered read data for host_addr (0 outside the windows) |
| cmd_tx_req | input | 1 | Request transmission of the buffer |
| cmd_abort | input | 1 | Abort a transmission that has not started |
| cmd_release | input | 1 | Release the shown receive buffer |
| cmd_clr_ovr | input | 1 | Clear the overrun flag |
| acc_code | input | 8 | Acceptance code for identifier bits 10..3 |
| acc_mask | input | 8 | Acceptance mask, 1 = don't care |
| tx_access | output | 1 | Transmit buffer writable by the host |
| tx_pending | output | 1 | Locked, waiting for the core to start |
| tx_active | output | 1 | Core is sending the buffer |
| core_tx_addr | input | 4 | Core transmit byte index |
| core_tx_rdata | output | 8 | Registered transmit byte |
| core_tx_start | input | 1 | Core begins sending |
| core_tx_done | input | 1 | Core finished sending |
| core_rx_we | input | 1 | Core receive byte write strobe |
| core_rx_addr | input | 4 | Core receive byte index (0 opens a frame) |
| core_rx_wdata | input | 8 | Core receive byte |
| core_rx_end | input | 1 | Frame completed correctly |
| core_rx_err | input | 1 | Frame ended with an error |
| rx_ready | output | 1 | At least one full receive buffer waits |
| ovr_flag | output | 1 | Data overrun seen |
| ovr_irq | output | 1 | One-cycle overrun interrupt pulse |

## Verification
Every command, host write and core strobe takes effect at the clock edge that samples it. The status outputs tx_access, tx_pending, tx_active, rx_ready, ovr_flag and ovr_irq therefore change one cycle after the stimulus. The bench drives each stimulus on a falling edge and samples on the next falling edge.

Both read ports have one register stage, so read data is due one cycle after the address is presented. The bench presents the address on a falling edge and reads the data on the next one. The overrun pulse is checked on the cycle after the third frame's end strobe, and again one cycle later to confirm it has dropped.

// File: rtl/canbuf_pkg.sv
package canbuf_pkg;
  typedef enum logic [1:0] {
    TX_FREE = 2'd0,
    TX_WAIT = 2'd1,
    TX_SEND = 2'd2
  } tx_state_t;
endpackage

// File: rtl/canbuf_filter.sv
module canbuf_filter #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] id_msbs,
  input  logic [DW-1:0] code,
  input  logic [DW-1:0] mask,
  output logic          hit
);
  // a mask bit set to one removes that identifier bit from the compare
  assign hit = (((id_msbs ^ code) & ~mask) == '0);
endmodule

// File: rtl/canbuf_tx.sv
module canbuf_tx
  import canbuf_pkg::*;
#(
  parameter int BYTES = 10,
  parameter int DW    = 8,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             h_we,
  input  logic [IDX_W-1:0] h_idx,
  input  logic [DW-1:0]    h_wdata,
  output logic [DW-1:0]    h_rdata,
  input  logic             req,
  input  logic             abort,
  input  logic             start,
  input  logic             done,
  input  logic [IDX_W-1:0] c_idx,
  output logic [DW-1:0]    c_rdata,
  output tx_state_t        state
);
  logic [DW-1:0] mem [0:BYTES-1];

  always_ff @(posedge clk) begin
    if (h_we && state == TX_FREE && h_idx < IDX_W'(BYTES))
      mem[h_idx] <= h_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)
      c_rdata <= '0;
    else if (c_idx < IDX_W'(BYTES))
      c_rdata <= mem[c_idx];
    else
      c_rdata <= '0;
  end

  assign h_rdata = (h_idx < IDX_W'(BYTES)) ? mem[h_idx] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= TX_FREE;
    end else begin
      case (state)
        TX_FREE: if (req)   state <= TX_WAIT;
        TX_WAIT: if (abort) state <= TX_FREE;
                 else if (start) state <= TX_SEND;
        TX_SEND: if (done)  state <= TX_FREE;
        default: state <= TX_FREE;
      endcase
    end
  end
endmodule

// File: rtl/canbuf_rx_pair.sv
module canbuf_rx_pair #(
  parameter int BYTES = 10,
  parameter int DW    = 8,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [DW-1:0]    wdata,
  input  logic             frame_end,
  input  logic             frame_err,
  input  logic [DW-1:0]    acc_code,
  input  logic [DW-1:0]    acc_mask,
  input  logic             release_i,
  input  logic             clr_ovr,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DW-1:0]    rd_data,
  output logic             ready,
  output logic             ovr,
  output logic             ovr_pulse
);
  localparam int DEPTH = 2 * BYTES;
  localparam int MA_W  = $clog2(DEPTH);

  logic [DW-1:0] mem [0:DEPTH-1];
  logic [1:0]    full, full_n;
  logic          rd_sel, rd_n;
  logic          tgt, room, open_q;
  logic [DW-1:0] id_q;
  logic          hit;

  wire space    = ~(full[0] & full[1]);
  wire free_sel = full[rd_sel] ? ~rd_sel : rd_sel;
  wire opening  = we && (waddr == '0);
  wire wr_sel   = opening ? free_sel : tgt;
  wire wr_room  = opening ? space : room;
  wire good_end = frame_end && !frame_err && open_q && hit;

  canbuf_filter #(.DW(DW)) u_filter (
    .id_msbs(id_q), .code(acc_code), .mask(acc_mask), .hit(hit)
  );

  function automatic logic [MA_W-1:0] flat(input logic sel, input logic [IDX_W-1:0] idx);
    return sel ? MA_W'(BYTES) + MA_W'(idx) : MA_W'(idx);
  endfunction

  always_ff @(posedge clk) begin
    if (we && wr_room && waddr < IDX_W'(BYTES))
      mem[flat(wr_sel, waddr)] <= wdata;
  end

  assign rd_data = (rd_idx < IDX_W'(BYTES)) ? mem[flat(rd_sel, rd_idx)] : '0;

  always_comb begin
    full_n = full;
    rd_n   = rd_sel;
    if (release_i && full[rd_sel]) begin
      full_n[rd_sel] = 1'b0;
      rd_n           = ~rd_sel;
    end
    if (good_end && room)
      full_n[tgt] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full      <= '0;
      rd_sel    <= 1'b0;
      tgt       <= 1'b0;
      room      <= 1'b0;
      open_q    <= 1'b0;
      id_q      <= '0;
      ready     <= 1'b0;
      ovr       <= 1'b0;
      ovr_pulse <= 1'b0;
    end else begin
      full      <= full_n;
      rd_sel    <= rd_n;
      ready     <= |full_n;
      ovr_pulse <= 1'b0;
      if (opening) begin
        tgt    <= free_sel;
        room   <= space;
        id_q   <= wdata;
        open_q <= 1'b1;
      end else if (frame_end || frame_err) begin
        open_q <= 1'b0;
      end
      if (good_end && !room) begin
        ovr       <= 1'b1;
        ovr_pulse <= 1'b1;
      end else if (clr_ovr) begin
        ovr <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/can_msgbuf.sv
module can_msgbuf
  import canbuf_pkg::*;
#(
  parameter int BYTES   = 10,
  parameter int DW      = 8,
  parameter int ADDR_W  = 6,
  parameter int TX_BASE = 'h2A,
  parameter int RX_BASE = 'h34
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_we,
  input  logic [DW-1:0]     host_wdata,
  output logic [DW-1:0]     host_rdata,
  input  logic              cmd_tx_req,
  input  logic              cmd_abort,
  input  logic              cmd_release,
  input  logic              cmd_clr_ovr,
  input  logic [DW-1:0]     acc_code,
  input  logic [DW-1:0]     acc_mask,
  output logic              tx_access,
  output logic              tx_pending,
  output logic              tx_active,
  input  logic [3:0]        core_tx_addr,
  output logic [DW-1:0]     core_tx_rdata,
  input  logic              core_tx_start,
  input  logic              core_tx_done,
  input  logic              core_rx_we,
  input  logic [3:0]        core_rx_addr,
  input  logic [DW-1:0]     core_rx_wdata,
  input  logic              core_rx_end,
  input  logic              core_rx_err,
  output logic              rx_ready,
  output logic              ovr_flag,
  output logic              ovr_irq
);
  localparam int IDX_W = 4;
  localparam logic [ADDR_W-1:0] TX_LO = ADDR_W'(TX_BASE);
  localparam logic [ADDR_W-1:0] TX_HI = ADDR_W'(TX_BASE + BYTES);
  localparam logic [ADDR_W-1:0] RX_LO = ADDR_W'(RX_BASE);
  localparam logic [ADDR_W-1:0] RX_HI = ADDR_W'(RX_BASE + BYTES);

  logic [ADDR_W-1:0] tx_off, rx_off;
  logic              in_tx, in_rx;
  logic [DW-1:0]     tx_hdata, rx_hdata;
  tx_state_t         tx_state;

  assign tx_off = host_addr - TX_LO;
  assign rx_off = host_addr - RX_LO;
  assign in_tx  = (host_addr >= TX_LO) && (host_addr < TX_HI);
  assign in_rx  = (host_addr >= RX_LO) && (host_addr < RX_HI);

  canbuf_tx #(.BYTES(BYTES), .DW(DW), .IDX_W(IDX_W)) u_tx (
    .clk(clk), .rst(rst),
    .h_we(host_we && in_tx), .h_idx(tx_off[IDX_W-1:0]), .h_wdata(host_wdata),
    .h_rdata(tx_hdata),
    .req(cmd_tx_req), .abort(cmd_abort), .start(core_tx_start), .done(core_tx_done),
    .c_idx(core_tx_addr), .c_rdata(core_tx_rdata), .state(tx_state)
  );

  canbuf_rx_pair #(.BYTES(BYTES), .DW(DW), .IDX_W(IDX_W)) u_rx (
    .clk(clk), .rst(rst),
    .we(core_rx_we), .waddr(core_rx_addr), .wdata(core_rx_wdata),
    .frame_end(core_rx_end), .frame_err(core_rx_err),
    .acc_code(acc_code), .acc_mask(acc_mask),
    .release_i(cmd_release), .clr_ovr(cmd_clr_ovr),
    .rd_idx(rx_off[IDX_W-1:0]), .rd_data(rx_hdata),
    .ready(rx_ready), .ovr(ovr_flag), .ovr_pulse(ovr_irq)
  );

  assign tx_access  = (tx_state == TX_FREE);
  assign tx_pending = (tx_state == TX_WAIT);
  assign tx_active  = (tx_state == TX_SEND);

  always_ff @(posedge clk) begin
    if (rst)        host_rdata <= '0;
    else if (in_tx) host_rdata <= tx_hdata;
    else if (in_rx) host_rdata <= rx_hdata;
    else            host_rdata <= '0;
  end
endmodule

// File: rtl/canbuf_checker.sv
module canbuf_checker (
  input logic clk,
  input logic rst,
  input logic cmd_tx_req,
  input logic cmd_abort,
  input logic cmd_clr_ovr,
  input logic core_tx_start,
  input logic core_tx_done,
  input logic core_rx_end,
  input logic tx_access,
  input logic tx_pending,
  input logic tx_active,
  input logic rx_ready,
  input logic ovr_flag,
  input logic ovr_irq
);
  p_onestate_r3: assert property (@(posedge clk) disable iff (rst)
    $countones({tx_access, tx_pending, tx_active}) == 1);
  p_lock_r3: assert property (@(posedge clk) disable iff (rst)
    (tx_access && cmd_tx_req) |=> !tx_access);
  p_abort_r4: assert property (@(posedge clk) disable iff (rst)
    (tx_pending && cmd_abort) |=> tx_access);
  p_noabort_r4: assert property (@(posedge clk) disable iff (rst)
    (tx_active && cmd_abort && !core_tx_done) |=> tx_active);
  p_done_r4: assert property (@(posedge clk) disable iff (rst)
    (tx_active && core_tx_done) |=> tx_access);
  p_ready_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_ready) |-> $past(core_rx_end));
  p_irq_r7: assert property (@(posedge clk) disable iff (rst)
    ovr_irq |-> (ovr_flag && $past(core_rx_end)));
  p_clr_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(ovr_flag) |-> $past(cmd_clr_ovr));
endmodule

bind can_msgbuf canbuf_checker i_chk (.*);

// File: tb/test_can_msgbuf.sv
module test_can_msgbuf;
  logic clk = 0;
  logic rst = 1;
  logic [5:0] host_addr = 0;
  logic host_we = 0;
  logic [7:0] host_wdata = 0;
  logic [7:0] host_rdata;
  logic cmd_tx_req = 0, cmd_abort = 0, cmd_release = 0, cmd_clr_ovr = 0;
  logic [7:0] acc_code = 0, acc_mask = 8'hFF;
  logic tx_access, tx_pending, tx_active;
  logic [3:0] core_tx_addr = 0;
  logic [7:0] core_tx_rdata;
  logic core_tx_start = 0, core_tx_done = 0;
  logic core_rx_we = 0;
  logic [3:0] core_rx_addr = 0;
  logic [7:0] core_rx_wdata = 0;
  logic core_rx_end = 0, core_rx_err = 0;
  logic rx_ready, ovr_flag, ovr_irq;

  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  can_msgbuf i_can_msgbuf (.*);

  // filter table: {code, mask, id, expected accept}
  localparam logic [24:0] FT [6] = '{
    {8'hA5, 8'h00, 8'hA5, 1'b1},
    {8'hA5, 8'h00, 8'hA4, 1'b0},
    {8'hA5, 8'h0F, 8'hAF, 1'b1},
    {8'hA5, 8'h0F, 8'hB5, 1'b0},
    {8'h00, 8'hFF, 8'h7E, 1'b1},
    {8'hF0, 8'h0F, 8'hF5, 1'b1}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  task automatic hwrite(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_we = 1;
    @(negedge clk); host_we = 0;
  endtask

  task automatic hread(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); host_addr = a;
    @(negedge clk); d = host_rdata;
  endtask

  task automatic frame(input logic [7:0] id, input logic [7:0] d0, input bit err);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      core_rx_we = 1; core_rx_addr = 4'(i);
      core_rx_wdata = (i == 0) ? id : (i == 1) ? 8'h01 : d0;
    end
    @(negedge clk); core_rx_we = 0;
    if (err) core_rx_err = 1; else core_rx_end = 1;
    @(negedge clk); core_rx_err = 0; core_rx_end = 0;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 tx_access", 8'(tx_access), 8'd1);
    chk("R1 tx_pending", 8'(tx_pending), 8'd0);
    chk("R1 rx_ready", 8'(rx_ready), 8'd0);
    chk("R1 ovr", 8'({ovr_flag, ovr_irq}), 8'd0);

    // R2 transmit buffer write and read back
    for (int i = 0; i < 10; i++) hwrite(6'h2A + 6'(i), 8'h10 + 8'(i));
    hread(6'h2D, d); chk("R2 host read", d, 8'h13);
    hread(6'h33, d); chk("R2 host read last", d, 8'h19);
    @(negedge clk); core_tx_addr = 4'd0;
    @(negedge clk); chk("R2 core read", core_tx_rdata, 8'h10);

    // R3 lock and ignored write
    pulse(cmd_tx_req);
    chk("R3 locked", 8'({tx_access, tx_pending}), 8'b01);
    hwrite(6'h2A, 8'hEE);
    hread(6'h2A, d); chk("R3 write ignored", d, 8'h10);

    // R4 abort before start, abort after start, done
    pulse(cmd_abort);
    chk("R4 abort unlocks", 8'(tx_access), 8'd1);
    pulse(cmd_tx_req);
    pulse(core_tx_start);
    chk("R4 active", 8'(tx_active), 8'd1);
    pulse(cmd_abort);
    chk("R4 abort ignored", 8'({tx_access, tx_active}), 8'b01);
    pulse(core_tx_done);
    chk("R4 done unlocks", 8'(tx_access), 8'd1);

    // R9 filter table
    for (int k = 0; k < 6; k++) begin
      acc_code = FT[k][24:17]; acc_mask = FT[k][16:9];
      frame(FT[k][8:1], 8'h5A, 0);
      chk($sformatf("R9 accept entry %0d", k), 8'(rx_ready), 8'(FT[k][0]));
      if (FT[k][0]) begin
        hread(6'h34, d); chk("R9 stored id", d, FT[k][8:1]);
      end
      pulse(cmd_release);
      chk("R9 released", 8'(rx_ready), 8'd0);
    end
    acc_code = 0; acc_mask = 8'hFF;

    // R5 and R6 double buffering
    frame(8'h11, 8'hA1, 0);
    chk("R5 ready", 8'(rx_ready), 8'd1);
    frame(8'h22, 8'hB1, 0);
    hread(6'h34, d); chk("R5 id", d, 8'h11);
    hread(6'h36, d); chk("R5 data", d, 8'hA1);
    pulse(cmd_release);
    chk("R6 still ready", 8'(rx_ready), 8'd1);
    hread(6'h34, d); chk("R6 second id", d, 8'h22);
    hread(6'h36, d); chk("R6 second data", d, 8'hB1);
    pulse(cmd_release);
    chk("R6 empty", 8'(rx_ready), 8'd0);

    // R7 overrun on a third frame
    frame(8'h31, 8'hC1, 0);
    frame(8'h32, 8'hC2, 0);
    frame(8'h33, 8'hC3, 0);
    chk("R7 irq", 8'({ovr_flag, ovr_irq}), 8'b11);
    @(negedge clk);
    chk("R7 irq one cycle", 8'({ovr_flag, ovr_irq}), 8'b10);
    hread(6'h34, d); chk("R7 first kept", d, 8'h31);
    pulse(cmd_release);
    hread(6'h34, d); chk("R7 second kept", d, 8'h32);
    hread(6'h36, d); chk("R7 second data", d, 8'hC2);
    // R8 clear
    pulse(cmd_clr_ovr);
    chk("R8 cleared", 8'(ovr_flag), 8'd0);
    pulse(cmd_release);

    // R10 error frame discarded
    frame(8'h44, 8'hD4, 1);
    chk("R10 not ready", 8'(rx_ready), 8'd0);
    frame(8'h55, 8'hD5, 0);
    hread(6'h34, d); chk("R10 next good", d, 8'h55);
    pulse(cmd_release);

    // R11 release with nothing held
    pulse(cmd_release);
    chk("R11 no effect", 8'(rx_ready), 8'd0);
    frame(8'h66, 8'hD6, 0);
    hread(6'h34, d); chk("R11 shown", d, 8'h66);
    hread(6'h36, d); chk("R11 data", d, 8'hD6);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule